// File: doc/BRIEF.md
# Dual-Channel 10-Bit PWM Generator

This block drives two pulse-width-modulated outputs from one shared 10-bit period counter. Each channel compares the running count against its own 10-bit duty value and drives an active level while the count is below that value. A per-channel polarity bit selects whether the active level is high or low. Software programs the block through a byte-wide write port. The low byte of the period and of each duty value has its own address. The upper bits of all three values are packed into one shared high byte, and the polarity bits sit at a further address.

New period and duty values first go into buffer registers. They reach the comparators only when the counter wraps, so a cycle in progress never sees a partial update. Because duty is an absolute count, rewriting only the period changes the frequency while each pulse keeps its width. The counter is shared with a general-purpose timer, which is modelled here only by the `pwm_en` input. While `pwm_en` is low, the timer owns the counter: the count is held at zero, both outputs sit at their inactive level, and buffered values pass straight to the active registers. Stopping the block, loading values and then enabling is therefore the only switching sequence needed.

Top module: `pwm2ch_top`

## Requirements
- R1: While enabled, the counter steps from 0 up to the active period value P and then returns to 0, so one PWM cycle lasts P+1 clocks and each output repeats that pattern.
- R2: After reset, every low byte and the shared high byte read as all ones (period and both duties 1023), both polarity bits are 0, and both outputs are at the inactive level (high).
- R3: An output is active while the count is below its duty value D. Over one cycle it is active for D clocks when D is at most P, for all P+1 clocks when D exceeds P, and never when D is 0.
- R4: Polarity bit c (bit c of the byte at address 4) makes channel c active high when 1 and active low when 0. A polarity write changes the output level on the next clock, with no wait for a wrap.
- R5: Duty writes while enabled land in a buffer and reach the comparator only at the edge where the counter returns to 0. A write captured on that same edge takes effect one full cycle later.
- R6: Rewriting only the period while enabled takes effect at the next wrap. The running cycle still ends at the old period, and the following cycles keep each channel's active time unchanged.
- R7: With `pwm_en` low, the counter is held at 0, both outputs show the inactive level, and buffered values are copied to the active registers on every clock. After `pwm_en` rises, counting starts from 0.
- R8: Register map (3-bit address): 0 = period low byte, 1 = channel 0 duty low byte, 2 = channel 1 duty low byte, 3 = high byte {2'b00, duty1[9:8], duty0[9:8], period[9:8]}, 4 = polarity in bits [1:0]. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_en | input | 1 | PWM mode enable; low hands the counter to the timer and holds it at 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 2 | PWM outputs, one bit per channel |

## Verification
The case that matters most is a software write meeting the counter wrap. A buffer write and the copy into the active registers can fall on the same clock edge, and the copy must take the value held before that edge. The bench provokes this by tracking the counter phase from the moment it enables the block. It places a duty write on the edge where the count returns to 0 and confirms that the following cycle still uses the old duty width. It then places period and duty writes mid-cycle and judges them by counting active clocks over exact windows. Each window must show the old value until the wrap and the new value after it, and each cycle boundary must fall where the old period places it.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;
   // width of one byte-wide register field
   localparam int LO_W = 8;

   // address of the shared high byte for a given channel count
   function automatic int addr_hi(input int nch);
      return nch + 1;
   endfunction

   // address of the polarity byte for a given channel count
   function automatic int addr_pol(input int nch);
      return nch + 2;
   endfunction
endpackage

// File: rtl/pwm2ch_regs.sv
module pwm2ch_regs
   import pwm2ch_pkg::*;
#(
   parameter int RES = 10,
   parameter int CH  = 2,
   parameter int AW  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LO_W-1:0]   wr_data,
   output logic [RES-1:0]    per_buf,
   output logic [CH*RES-1:0] duty_buf,
   output logic [CH-1:0]     pol
);
   localparam int HB    = RES - LO_W;
   localparam int A_HI  = addr_hi(CH);
   localparam int A_POL = addr_pol(CH);

   // elaboration-time parameter checks
   if (RES <= LO_W || RES > 2*LO_W) begin : g_bad_res
      $error("pwm2ch_regs: RES must lie between LO_W+1 and 2*LO_W");
   end
   if ((CH + 1) * HB > LO_W || CH > LO_W || CH < 1) begin : g_bad_ch
      $error("pwm2ch_regs: high fields or polarity bits do not fit one byte");
   end
   if ((1 << AW) < CH + 3) begin : g_bad_aw
      $error("pwm2ch_regs: address width too small for register map");
   end

   logic [LO_W-1:0] per_lo;
   logic [HB-1:0]   per_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_lo <= '1;
         per_hi <= '1;
      end else begin
         if (wr_en && wr_addr == AW'(0))     per_lo <= wr_data;
         if (wr_en && wr_addr == AW'(A_HI))  per_hi <= wr_data[HB-1:0];
      end
   end
   assign per_buf = {per_hi, per_lo};

   for (genvar c = 0; c < CH; c++) begin : g_duty
      logic [LO_W-1:0] d_lo;
      logic [HB-1:0]   d_hi;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_lo <= '1;
            d_hi <= '1;
         end else begin
            if (wr_en && wr_addr == AW'(c + 1)) d_lo <= wr_data;
            if (wr_en && wr_addr == AW'(A_HI))  d_hi <= wr_data[(c+1)*HB +: HB];
         end
      end
      assign duty_buf[c*RES +: RES] = {d_hi, d_lo};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              pol <= '0;
      else if (wr_en && wr_addr == AW'(A_POL)) pol <= wr_data[CH-1:0];
   end
endmodule

// File: rtl/pwm2ch_cnt.sv
module pwm2ch_cnt #(
   parameter int RES = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic [RES-1:0] per_buf,
   output logic [RES-1:0] cnt,
   output logic [RES-1:0] per_act,
   output logic           load
);
   logic at_end;
   assign at_end = (cnt == per_act);
   // copy buffers at wrap, or continuously while the timer owns the counter
   assign load   = !en || at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         per_act <= '1;
      end else begin
         if (load) per_act <= per_buf;
         if (load) cnt     <= '0;
         else      cnt     <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm2ch_chan.sv
module pwm2ch_chan #(
   parameter int RES = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en,
   input  logic           load,
   input  logic [RES-1:0] duty_buf,
   input  logic [RES-1:0] cnt,
   input  logic           pol,
   output logic [RES-1:0] duty_act,
   output logic           out
);
   logic active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_act <= '1;
      else if (load) duty_act <= duty_buf;
   end

   assign active = en && (cnt < duty_act);
   assign out    = active ? pol : ~pol;
endmodule

// File: rtl/pwm2ch_top.sv
module pwm2ch_top
   import pwm2ch_pkg::*;
#(
   parameter int RES = 10,
   parameter int CH  = 2,
   parameter int AW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pwm_en,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [LO_W-1:0] wr_data,
   output logic [CH-1:0]   pwm_out
);
   logic [RES-1:0]    per_buf;
   logic [CH*RES-1:0] duty_buf;
   logic [CH-1:0]     pol_q;
   logic [RES-1:0]    cnt;
   logic [RES-1:0]    per_act;
   logic              load;
   logic [CH*RES-1:0] duty_act;

   pwm2ch_regs #(.RES(RES), .CH(CH), .AW(AW)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .per_buf  (per_buf),
      .duty_buf (duty_buf),
      .pol      (pol_q)
   );

   pwm2ch_cnt #(.RES(RES)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (pwm_en),
      .per_buf (per_buf),
      .cnt     (cnt),
      .per_act (per_act),
      .load    (load)
   );

   for (genvar c = 0; c < CH; c++) begin : g_ch
      pwm2ch_chan #(.RES(RES)) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (pwm_en),
         .load     (load),
         .duty_buf (duty_buf[c*RES +: RES]),
         .cnt      (cnt),
         .pol      (pol_q[c]),
         .duty_act (duty_act[c*RES +: RES]),
         .out      (pwm_out[c])
      );
   end
endmodule

// File: rtl/pwm2ch_chk.sv
module pwm2ch_chk #(
   parameter int RES = 10,
   parameter int CH  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwm_en,
   input logic [CH-1:0]     pwm_out,
   input logic [CH-1:0]     pol_q,
   input logic [RES-1:0]    cnt,
   input logic [RES-1:0]    per_act,
   input logic [CH*RES-1:0] duty_act
);
   // R1: the count never passes the active period
   a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);

   // R1: at the period end the counter returns to zero
   a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt == per_act) |=> (cnt == '0));

   // R1: otherwise it advances by one
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt != per_act) |=> (cnt == $past(cnt) + 1'b1));

   // R5: active duties change only at a wrap
   a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt != per_act) |=> $stable(duty_act));

   // R6: active period changes only at a wrap
   a_r6_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_en && cnt != per_act) |=> $stable(per_act));

   // R7: disabled mode holds the counter at zero
   a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en |=> (cnt == '0));

   // R7: disabled mode shows the inactive level on every channel
   a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_en |-> (pwm_out == ~pol_q));
endmodule

bind pwm2ch_top pwm2ch_chk #(.RES(RES), .CH(CH)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwm_en   (pwm_en),
   .pwm_out  (pwm_out),
   .pol_q    (pol_q),
   .cnt      (cnt),
   .per_act  (per_act),
   .duty_act (duty_act)
);

// File: tb/test_pwm2ch_top.sv
module test_pwm2ch_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       pwm_en;
   logic       wr_en;
   logic [2:0] wr_addr;
   logic [7:0] wr_data;
   logic [1:0] pwm_out;

   int n_chk  = 0;
   int n_fail = 0;
   int a0, a1;

   always #10 clk = ~clk;

   pwm2ch_top i_pwm2ch_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwm_en  (pwm_en),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pwm_out (pwm_out)
   );

   // vectors: {period, duty0, duty1, polarity}
   localparam int NV = 7;
   localparam logic [31:0] VEC [NV] = '{
      {10'd9,    10'd3,    10'd7,   2'b11},
      {10'd9,    10'd0,    10'd10,  2'b11},
      {10'd15,   10'd20,   10'd1,   2'b00},
      {10'd4,    10'd4,    10'd5,   2'b10},
      {10'd0,    10'd0,    10'd1,   2'b11},
      {10'd300,  10'd256,  10'd299, 2'b01},
      {10'd1023, 10'd1023, 10'd512, 2'b11}
   };

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic program_all(input logic [9:0] p, input logic [9:0] d0,
                              input logic [9:0] d1, input logic [1:0] pl);
      wr(3'd0, p[7:0]);
      wr(3'd1, d0[7:0]);
      wr(3'd2, d1[7:0]);
      wr(3'd3, {2'b00, d1[9:8], d0[9:8], p[9:8]});
      wr(3'd4, {6'b0, pl});
      @(negedge clk);
   endtask

   // count clocks at the active level, one sample per clock
   task automatic window(input int n, input logic [1:0] pl, output int c0, output int c1);
      c0 = 0; c1 = 0;
      for (int i = 0; i < n; i++) begin
         #1;
         if (pwm_out[0] == pl[0]) c0++;
         if (pwm_out[1] == pl[1]) c1++;
         @(negedge clk);
      end
   endtask

   function automatic int exp_act(input int p, input int d);
      return (d > p) ? p + 1 : d;
   endfunction

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; pwm_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R2 reset outputs inactive", int'(pwm_out), 3);
      @(negedge clk);

      // R2 reset values: period and duties 1023, active low
      pwm_en = 1'b1;
      window(1024, 2'b00, a0, a1);
      chk("R2 reset duty0 width", a0, 1023);
      chk("R2 reset duty1 width", a1, 1023);
      pwm_en = 1'b0;
      @(negedge clk);

      // vector table: R3 widths, R4 polarity, R1 wrap, R7 direct load
      for (int v = 0; v < NV; v++) begin
         logic [9:0] p, d0, d1;
         logic [1:0] pl;
         {p, d0, d1, pl} = VEC[v];
         program_all(p, d0, d1, pl);
         pwm_en = 1'b1;
         window(int'(p) + 1, pl, a0, a1);
         chk($sformatf("R3 vec%0d ch0 width", v), a0, exp_act(int'(p), int'(d0)));
         chk($sformatf("R3 R4 vec%0d ch1 width", v), a1, exp_act(int'(p), int'(d1)));
         window(1, pl, a0, a1);
         chk($sformatf("R1 vec%0d ch0 cycle restart", v), a0, (d0 > 0) ? 1 : 0);
         chk($sformatf("R1 vec%0d ch1 cycle restart", v), a1, (d1 > 0) ? 1 : 0);
         pwm_en = 1'b0;
         @(negedge clk);
      end

      // R5 mid-cycle duty write waits for the wrap
      program_all(10'd9, 10'd3, 10'd3, 2'b11);
      pwm_en = 1'b1;
      window(6, 2'b11, a0, a1);          // count 0..5
      chk("R3 directed ch0 partial", a0, 3);
      wr(3'd1, 8'd8);                    // lands on edge 6->7
      window(3, 2'b11, a0, a1);          // count 7..9
      chk("R5 old duty kept to wrap", a0, 0);
      window(10, 2'b11, a0, a1);
      chk("R5 new duty after wrap", a0, 8);
      chk("R5 other channel unchanged", a1, 3);

      // R5 write on the wrap edge itself
      window(9, 2'b11, a0, a1);          // count 0..8
      chk("R5 pre-wrap width", a0, 8);
      wr(3'd1, 8'd2);                    // lands on edge 9->0
      window(10, 2'b11, a0, a1);
      chk("R5 same-edge write deferred one cycle", a0, 8);
      window(10, 2'b11, a0, a1);
      chk("R5 same-edge write applied", a0, 2);

      // R6 period-only change keeps pulse width
      window(6, 2'b11, a0, a1);          // count 0..5
      wr(3'd0, 8'd19);                   // lands on edge 6->7
      window(3, 2'b11, a0, a1);          // count 7..9, old period
      chk("R6 running cycle ch0", a0, 0);
      window(20, 2'b11, a0, a1);
      chk("R6 ch0 width kept", a0, 2);
      chk("R6 ch1 width kept", a1, 3);
      window(1, 2'b11, a0, a1);
      chk("R6 R1 wrap at new period", a0, 1);

      // R7 disable shows inactive level, R4 polarity is immediate
      pwm_en = 1'b0;
      #1;
      chk("R7 disabled inactive level", int'(pwm_out), 0);
      @(negedge clk);
      wr(3'd4, 8'h00);
      #1;
      chk("R4 polarity flips inactive level", int'(pwm_out), 3);
      @(negedge clk);

      // R8 writes to unmapped addresses are ignored
      wr(3'd5, 8'h00);
      wr(3'd6, 8'h00);
      wr(3'd7, 8'h00);
      wr(3'd4, 8'h03);
      @(negedge clk);
      pwm_en = 1'b1;
      window(20, 2'b11, a0, a1);
      chk("R7 R8 restart ch0 width", a0, 2);
      chk("R8 ch1 width untouched", a1, 3);
      window(1, 2'b11, a0, a1);
      chk("R8 period untouched", a1, 1);

      summary();
   end
endmodule